// File: doc/BRIEF.md
# Key Combination Detector

This block watches four active-low inputs, a power button and three keys, for up to four programmable combinations. Each combination slot names a subset of the inputs and is active only when every input in that subset reads low after an optional per-input polarity flip. A combination arms its timer on the edge where it turns from inactive to active. It must then stay active through a shared debounce interval and after that through its own hold interval before it fires. A combination that drops early abandons the attempt. One that has fired does not fire again until it has been released and pressed anew.

A firing slot triggers whichever of its four actions are enabled: a sticky cause bit that drives an interrupt, an active-low embedded-controller reset pulse of programmable width, a one-cycle system reset request, and a one-cycle battery-disconnect request. All intervals are counted in ticks of one prescaler shared by every slot. The tick falls every `TICK_DIV` clock cycles.

Configuration enters through a small write port: an address, 16 bits of data and a write strobe. A lock input freezes the configuration until the next reset. Software clears cause bits through the same port, and the lock does not block clearing.

Top module: `kcombo_det`

## Requirements
- R1: A slot's combination is active only when its select field (bits 3:0 of its control word) is nonzero and every selected effective input is 0. Input bit 0 is the power button and bits 1 to 3 are keys 0 to 2. A slot with an empty select field never fires.
- R2: The effective input is the raw input XOR the polarity word at address 0, bit for bit, and it is applied before any combination is evaluated.
- R3: A slot arms only on an inactive-to-active transition of its combination. After it fires, it stays quiet until the combination has gone inactive and then active again.
- R4: A slot fires in the cycle in which it is armed and has counted debounce (address 1) plus hold (address 8+n for slot n) ticks since arming. Its action outputs change at the next clock edge. A tick occurs every `TICK_DIV` cycles from reset.
- R5: If the combination goes inactive before the count is reached, the count is discarded and no action is taken.
- R6: Control word bits 4, 5, 6 and 7 enable, in that order, the interrupt cause, the reset pulse, the system reset request and the battery-disconnect request. Control words sit at addresses 4+n for slot n.
- R7: Cause bit n is set when slot n fires with its interrupt enable set, and it stays set until a write to address 3 with data bit n set clears it. A set in the same cycle wins over a clear. `intr_o` is the OR of the cause bits.
- R8: A firing slot with the reset-pulse enable set loads the width at address 2. `ec_rst_no` is low while that count is nonzero, and the count falls by one on each tick. A width of 0 gives no pulse, and a new firing reloads the width.
- R9: `sys_rst_req_o` and `batt_cut_req_o` each go high for one cycle after a firing slot with the matching enable.
- R10: Once `cfg_lock_i` has been high at a clock edge, configuration writes are ignored until reset, including a write in that same cycle. Cause clears still take effect.
- R11: In reset, and until the first firing, `intr_o`, the cause bits and both requests are 0 and `ec_rst_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_ni | input | 4 | Raw inputs, active low: bit 0 power, bits 1-3 keys 0-2 |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_lock_i | input | 1 | Freezes the configuration until reset |
| intr_o | output | 1 | Interrupt, OR of the cause bits |
| intr_cause_o | output | 4 | Sticky per-slot cause bits |
| ec_rst_no | output | 1 | Embedded-controller reset, active low |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| batt_cut_req_o | output | 1 | One-cycle battery-disconnect request |

## Verification
Every output is a register, so a firing in cycle k shows on the cause bits, the requests and the falling edge of `ec_rst_no` right after edge k. The reset pulse ends only at the edge of a tick cycle, so its length depends on the tick phase at firing. The bench keeps its own tick phase, per-slot counts and pulse counter in integers that it updates at each rising edge from the inputs held since the previous falling edge. It then compares all outputs at every falling edge, which makes every one-cycle result due exactly one edge after its cause. Stimulus changes only at falling edges, so the model and the design see the same inputs.

// File: rtl/kcd_pkg.sv
package kcd_pkg;
  localparam int unsigned NKEY    = 4;
  localparam int unsigned NACT    = 4;
  localparam int unsigned NCOMBO  = 4;
  localparam int unsigned CFG_AW  = 4;
  localparam int unsigned CFG_DW  = 16;

  typedef enum logic [1:0] {
    ACT_INTR   = 2'd0,
    ACT_ECRST  = 2'd1,
    ACT_SYSRST = 2'd2,
    ACT_BATT   = 2'd3
  } act_idx_e;

  typedef struct packed {
    logic [NACT-1:0] act;
    logic [NKEY-1:0] sel;
  } combo_ctl_t;

  localparam logic [CFG_AW-1:0] ADDR_INV   = 4'd0;
  localparam logic [CFG_AW-1:0] ADDR_DEB   = 4'd1;
  localparam logic [CFG_AW-1:0] ADDR_ECW   = 4'd2;
  localparam logic [CFG_AW-1:0] ADDR_CLR   = 4'd3;
  localparam int unsigned       ADDR_CTL0  = 4;
  localparam int unsigned       ADDR_TIME0 = 8;
endpackage

// File: rtl/kcd_tick.sv
module kcd_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kcd_cfg.sv
module kcd_cfg
  import kcd_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [CFG_AW-1:0]             addr_i,
  input  logic [CFG_DW-1:0]             wdata_i,
  input  logic                          lock_i,
  output logic [NKEY-1:0]               inv_o,
  output logic [TW-1:0]                 deb_o,
  output logic [TW-1:0]                 ecw_o,
  output combo_ctl_t [NCOMBO-1:0]       ctl_o,
  output logic [NCOMBO-1:0][TW-1:0]     time_o,
  output logic [NCOMBO-1:0]             clr_o,
  output logic                          locked_o
);
  logic                      locked_q, locked_d;
  logic [NKEY-1:0]           inv_q, inv_d;
  logic [TW-1:0]             deb_q, deb_d, ecw_q, ecw_d;
  combo_ctl_t [NCOMBO-1:0]   ctl_q, ctl_d;
  logic [NCOMBO-1:0][TW-1:0] time_q, time_d;
  logic                      wen;

  assign wen = wr_i & ~(locked_q | lock_i);

  always_comb begin
    locked_d = locked_q | lock_i;
    inv_d    = inv_q;
    deb_d    = deb_q;
    ecw_d    = ecw_q;
    ctl_d    = ctl_q;
    time_d   = time_q;
    if (wen) begin
      if (addr_i == ADDR_INV) inv_d = wdata_i[NKEY-1:0];
      if (addr_i == ADDR_DEB) deb_d = wdata_i[TW-1:0];
      if (addr_i == ADDR_ECW) ecw_d = wdata_i[TW-1:0];
      for (int i = 0; i < NCOMBO; i++) begin
        if (addr_i == CFG_AW'(ADDR_CTL0 + i))
          ctl_d[i] = combo_ctl_t'(wdata_i[NACT+NKEY-1:0]);
        if (addr_i == CFG_AW'(ADDR_TIME0 + i))
          time_d[i] = wdata_i[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      inv_q    <= '0;
      deb_q    <= '0;
      ecw_q    <= '0;
      ctl_q    <= '0;
      time_q   <= '0;
    end else begin
      locked_q <= locked_d;
      inv_q    <= inv_d;
      deb_q    <= deb_d;
      ecw_q    <= ecw_d;
      ctl_q    <= ctl_d;
      time_q   <= time_d;
    end
  end

  assign clr_o    = (wr_i && addr_i == ADDR_CLR) ? wdata_i[NCOMBO-1:0] : '0;
  assign inv_o    = inv_q;
  assign deb_o    = deb_q;
  assign ecw_o    = ecw_q;
  assign ctl_o    = ctl_q;
  assign time_o   = time_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/kcd_slot.sv
module kcd_slot
  import kcd_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NKEY-1:0] eff_i,
  input  logic [NKEY-1:0] sel_i,
  input  logic [TW-1:0]   deb_i,
  input  logic [TW-1:0]   det_i,
  output logic            fire_o
);
  logic          act;
  logic [TW:0]   target;
  logic          pact_q, pact_d, armed_q, armed_d;
  logic [TW:0]   cnt_q, cnt_d;

  // All selected inputs low, and at least one input selected
  assign act    = (|sel_i) && ((eff_i & sel_i) == '0);
  assign target = {1'b0, deb_i} + {1'b0, det_i};

  always_comb begin
    pact_d  = act;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    if (!act) begin
      armed_d = 1'b0;
    end else if (!pact_q) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q) begin
      if (cnt_q == target) begin
        fire_o  = 1'b1;
        armed_d = 1'b0;
      end else if (tick_i) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pact_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pact_q  <= pact_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/kcd_action.sv
module kcd_action
  import kcd_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [NCOMBO-1:0]       fire_i,
  input  combo_ctl_t [NCOMBO-1:0] ctl_i,
  input  logic [TW-1:0]           ecw_i,
  input  logic [NCOMBO-1:0]       clr_i,
  output logic [NCOMBO-1:0]       cause_o,
  output logic                    intr_o,
  output logic                    ec_rst_no,
  output logic                    sys_o,
  output logic                    batt_o
);
  logic [NCOMBO-1:0] en_intr, en_ec, en_sys, en_batt;
  logic [NCOMBO-1:0] st_q, st_d;
  logic [TW-1:0]     ec_q, ec_d;
  logic              sys_q, sys_d, batt_q, batt_d;

  for (genvar i = 0; i < NCOMBO; i++) begin : g_en
    assign en_intr[i] = ctl_i[i].act[ACT_INTR];
    assign en_ec[i]   = ctl_i[i].act[ACT_ECRST];
    assign en_sys[i]  = ctl_i[i].act[ACT_SYSRST];
    assign en_batt[i] = ctl_i[i].act[ACT_BATT];
  end

  always_comb begin
    st_d   = (st_q & ~clr_i) | (fire_i & en_intr);
    sys_d  = |(fire_i & en_sys);
    batt_d = |(fire_i & en_batt);
    ec_d   = ec_q;
    if (|(fire_i & en_ec))          ec_d = ecw_i;
    else if (ec_q != '0 && tick_i)  ec_d = ec_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      ec_q   <= '0;
      sys_q  <= 1'b0;
      batt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ec_q   <= ec_d;
      sys_q  <= sys_d;
      batt_q <= batt_d;
    end
  end

  assign cause_o   = st_q;
  assign intr_o    = |st_q;
  assign ec_rst_no = (ec_q == '0);
  assign sys_o     = sys_q;
  assign batt_o    = batt_q;
endmodule

// File: rtl/kcombo_det.sv
module kcombo_det
  import kcd_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned TIME_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        key_ni,
  input  logic              cfg_wr_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              cfg_lock_i,
  output logic              intr_o,
  output logic [3:0]        intr_cause_o,
  output logic              ec_rst_no,
  output logic              sys_rst_req_o,
  output logic              batt_cut_req_o
);
  logic                          tick;
  logic [NKEY-1:0]               inv, eff;
  logic [TIME_W-1:0]             deb, ecw;
  combo_ctl_t [NCOMBO-1:0]       ctl;
  logic [NCOMBO-1:0][TIME_W-1:0] tdet;
  logic [NCOMBO-1:0]             clr, fire;
  logic                          locked;

  kcd_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  kcd_cfg #(.TW(TIME_W)) u_cfg (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_i (cfg_wr_i), .addr_i (cfg_addr_i), .wdata_i (cfg_wdata_i),
    .lock_i (cfg_lock_i),
    .inv_o (inv), .deb_o (deb), .ecw_o (ecw), .ctl_o (ctl),
    .time_o (tdet), .clr_o (clr), .locked_o (locked)
  );

  assign eff = key_ni ^ inv;

  for (genvar i = 0; i < NCOMBO; i++) begin : g_slot
    kcd_slot #(.TW(TIME_W)) u_slot (
      .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
      .eff_i (eff), .sel_i (ctl[i].sel),
      .deb_i (deb), .det_i (tdet[i]), .fire_o (fire[i])
    );
  end

  kcd_action #(.TW(TIME_W)) u_act (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
    .fire_i (fire), .ctl_i (ctl), .ecw_i (ecw), .clr_i (clr),
    .cause_o (intr_cause_o), .intr_o (intr_o), .ec_rst_no (ec_rst_no),
    .sys_o (sys_rst_req_o), .batt_o (batt_cut_req_o)
  );
endmodule

// File: rtl/kcd_chk.sv
module kcd_chk
  import kcd_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick,
  input logic [NCOMBO-1:0]         fire,
  input combo_ctl_t [NCOMBO-1:0]   ctl,
  input logic [NKEY-1:0]           inv,
  input logic [TW-1:0]             deb,
  input logic [TW-1:0]             ecw,
  input logic [NCOMBO-1:0][TW-1:0] tdet,
  input logic                      locked,
  input logic                      cfg_wr_i,
  input logic [3:0]                cfg_addr_i,
  input logic [15:0]               cfg_wdata_i,
  input logic [3:0]                intr_cause_o,
  input logic                      ec_rst_no
);
  // R8: the pulse ends only at the edge closing a tick cycle
  assert_ec_release_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ec_rst_no) |-> $past(tick));

  // R10: a frozen configuration never moves
  assert_lock_freezes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked) |-> ($stable(inv) && $stable(deb) && $stable(ecw)
                       && $stable(ctl) && $stable(tdet)));

  for (genvar i = 0; i < NCOMBO; i++) begin : g_slot_chk
    // R7: cause bits only fall through a clear write
    assert_cause_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(intr_cause_o[i]) &&
       !($past(cfg_wr_i) && $past(cfg_addr_i) == ADDR_CLR && $past(cfg_wdata_i[i])))
      |-> intr_cause_o[i]);

    // R3: one firing per arming
    assert_single_fire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire[i] |=> !fire[i]);

    // R1: an empty selection never fires
    assert_fire_needs_sel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire[i] |-> (ctl[i].sel != '0));
  end
endmodule

bind kcombo_det kcd_chk #(.TW(TIME_W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .tick (tick), .fire (fire), .ctl (ctl),
  .inv (inv), .deb (deb), .ecw (ecw), .tdet (tdet), .locked (locked),
  .cfg_wr_i (cfg_wr_i), .cfg_addr_i (cfg_addr_i), .cfg_wdata_i (cfg_wdata_i),
  .intr_cause_o (intr_cause_o), .ec_rst_no (ec_rst_no)
);

// File: tb/sim_kcombo_det.sv
`timescale 1ns/1ps
module sim_kcombo_det;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  keys;
  logic        cfg_wr, cfg_lock;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        intr, ec_n, sysr, batt;
  logic [3:0]  cause;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;  // 125 MHz

  kcombo_det #(.TICK_DIV(DIV), .TIME_W(16)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .key_ni (keys),
    .cfg_wr_i (cfg_wr), .cfg_addr_i (cfg_addr), .cfg_wdata_i (cfg_wdata),
    .cfg_lock_i (cfg_lock),
    .intr_o (intr), .intr_cause_o (cause), .ec_rst_no (ec_n),
    .sys_rst_req_o (sysr), .batt_cut_req_o (batt)
  );

  // ---------------- reference model ----------------
  int       pc, ec;
  int       arm [4];
  int       cnt [4];
  bit       pact [4];
  bit [7:0] m_ctl [4];
  int       m_time [4];
  bit [3:0] m_inv, st;
  int       m_deb, m_ecw;
  bit       m_lock, m_sys, m_batt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc = 0; ec = 0; st = 0; m_inv = 0; m_deb = 0; m_ecw = 0;
      m_lock = 0; m_sys = 0; m_batt = 0;
      for (int i = 0; i < 4; i++) begin
        arm[i] = 0; cnt[i] = 0; pact[i] = 0; m_ctl[i] = 0; m_time[i] = 0;
      end
    end else begin
      bit tk;
      bit [3:0] eff, fire, clr;
      bit ecf;
      tk  = (pc == DIV - 1);
      pc  = tk ? 0 : pc + 1;
      eff = keys ^ m_inv;
      fire = 0;
      for (int i = 0; i < 4; i++) begin
        bit a;
        a = (m_ctl[i][3:0] != 0) && ((eff & m_ctl[i][3:0]) == 0);
        if (!a) arm[i] = 0;
        else if (!pact[i]) begin arm[i] = 1; cnt[i] = 0; end
        else if (arm[i] != 0) begin
          if (cnt[i] == m_deb + m_time[i]) begin fire[i] = 1; arm[i] = 0; end
          else if (tk) cnt[i]++;
        end
        pact[i] = a;
      end
      ecf = 0; m_sys = 0; m_batt = 0;
      clr = (cfg_wr && cfg_addr == 3) ? cfg_wdata[3:0] : 4'h0;
      st  = st & ~clr;
      for (int i = 0; i < 4; i++) if (fire[i]) begin
        if (m_ctl[i][4]) st[i] = 1;
        if (m_ctl[i][5]) ecf = 1;
        if (m_ctl[i][6]) m_sys = 1;
        if (m_ctl[i][7]) m_batt = 1;
      end
      if (ecf) ec = m_ecw;
      else if (ec != 0 && tk) ec--;
      if (cfg_wr && !(m_lock || cfg_lock)) begin
        case (cfg_addr)
          4'd0: m_inv = cfg_wdata[3:0];
          4'd1: m_deb = int'(cfg_wdata);
          4'd2: m_ecw = int'(cfg_wdata);
          4'd4, 4'd5, 4'd6, 4'd7: m_ctl[cfg_addr - 4] = cfg_wdata[7:0];
          4'd8, 4'd9, 4'd10, 4'd11: m_time[cfg_addr - 8] = int'(cfg_wdata);
          default: ;
        endcase
      end
      if (cfg_lock) m_lock = 1;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (intr !== (st != 0) || cause !== st || ec_n !== (ec == 0) ||
          sysr !== m_sys || batt !== m_batt) begin
        errors++;
        $display("FAIL %s: got intr=%b cause=%b ec_n=%b sys=%b batt=%b, exp intr=%b cause=%b ec_n=%b sys=%b batt=%b",
                 cur_req, intr, cause, ec_n, sysr, batt,
                 (st != 0), st, (ec == 0), m_sys, m_batt);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end, exp end of stimulus");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; keys = 4'hF; cfg_wr = 0; cfg_lock = 0; cfg_addr = 0; cfg_wdata = 0;
    wait_n(3);
    // R11: reset state at the ports
    vectors++;
    if (intr !== 0 || cause !== 0 || ec_n !== 1 || sysr !== 0 || batt !== 0) begin
      errors++;
      $display("FAIL R11: got intr=%b cause=%b ec_n=%b sys=%b batt=%b, exp 0 0000 1 0 0",
               intr, cause, ec_n, sysr, batt);
    end
    rst_n = 1'b1;
    wait_n(2);

    // configuration: debounce 2, pulse 3 ticks
    cur_req = "R6";
    wr(4'd1, 16'd2);
    wr(4'd2, 16'd3);
    wr(4'd4, 16'h0037);  // slot0: power+key0+key1, intr+pulse
    wr(4'd8, 16'd3);
    wr(4'd5, 16'h0048);  // slot1: key2, system reset
    wr(4'd9, 16'd1);
    wr(4'd6, 16'h0081);  // slot2: power alone, battery cut
    wr(4'd10, 16'd2);
    wr(4'd7, 16'h00F0);  // slot3: no selection, all actions (R1)
    wr(4'd11, 16'd0);

    // R1: partial combination must not fire slot0
    cur_req = "R1";
    keys = 4'b1001; wait_n(40);
    // R4, R6, R8: complete combination fires slot0 and slot2
    cur_req = "R4";
    keys = 4'b1000; wait_n(40);
    cur_req = "R3";
    wait_n(30);
    keys = 4'hF; wait_n(5);

    // R7: clear the cause of slot0 only
    cur_req = "R7";
    wr(4'd3, 16'h0001); wait_n(3);

    // R5: key2 released before expiry
    cur_req = "R5";
    keys = 4'b0111; wait_n(5);
    keys = 4'hF; wait_n(20);
    // R9: key2 held long enough gives one request pulse
    cur_req = "R9";
    keys = 4'b0111; wait_n(40);
    keys = 4'hF; wait_n(5);

    // R2: inverting key2 makes a released key count as pressed
    cur_req = "R2";
    wr(4'd0, 16'h0008); wait_n(30);
    wr(4'd0, 16'h0000); wait_n(10);

    // R8: zero width gives no pulse; retrigger reloads
    cur_req = "R8";
    wr(4'd2, 16'd0);
    keys = 4'b1000; wait_n(40);
    keys = 4'hF; wait_n(5);
    wr(4'd2, 16'd5);
    keys = 4'b1000; wait_n(60);
    keys = 4'hF; wait_n(5);

    // R10: lock with a same-cycle write, then try further writes
    cur_req = "R10";
    cfg_lock = 1; cfg_wr = 1; cfg_addr = 4'd1; cfg_wdata = 16'd9;
    @(negedge clk);
    cfg_lock = 0; cfg_wr = 0;
    wr(4'd8, 16'd20);
    wr(4'd5, 16'h0000);
    wr(4'd3, 16'h000F);  // clears still act
    keys = 4'b1000; wait_n(40);
    keys = 4'hF; wait_n(5);
    keys = 4'b0111; wait_n(30);
    keys = 4'hF; wait_n(10);

    finish_run();
  end
endmodule